// File: doc/BRIEF.md
# Self-Correcting 1-3-4-7 Sequence Generator

This block is a synchronous three-bit state machine that steps through the decimal values 1, 3, 4, 7 and then starts again. All three state bits are held in JK-style storage cells. The cells share one clock and one set of excitation equations. Bit 2 of the state is called B, bit 1 is C and bit 0 is D. The four codes outside the cycle each have a defined successor that leads back into the cycle. Because of this, the machine recovers from any power-up value without help.

A clock enable lets the generator advance only when the surrounding logic is ready. A synchronous reset puts it at the first value of the sequence. A seed port can force any of the eight codes into the state, so that recovery from the unused codes can be exercised directly. A start flag marks the cycle in which the sequence begins again. A build parameter chooses between two implementations of the storage cell: a decoded hold/reset/set/toggle selector, or the characteristic equation. Both implementations behave the same.

Top module: `seqgen_1347`

## Requirements
- R1: With en_i high and no reset or seed, state_o advances one step per rising clock edge through 3'b001, 3'b011, 3'b100, 3'b111 and back to 3'b001. Bit 2 is B, bit 1 is C and bit 0 is D.
- R2: When rst_i is high at a rising edge, state_o is 3'b001 after that edge. This holds regardless of en_i, seed_we_i or seed_val_i.
- R3: The codes outside the cycle advance, on an enabled edge, as follows: 3'b000 goes to 3'b001, 3'b010 goes to 3'b011, 3'b101 goes to 3'b111 and 3'b110 goes to 3'b111.
- R4: With en_i low and no reset or seed, state_o keeps its value across clock edges.
- R5: When seed_we_i is high at a rising edge and rst_i is low, state_o equals seed_val_i after that edge. This holds whatever the value of en_i.
- R6: start_o is high exactly while state_o is 3'b001.
- R7: Each bit is a JK cell. A cell with J=0, K=0 holds its value; J=0, K=1 clears it; J=1, K=0 sets it; J=1, K=1 toggles it. The cells are driven by these equations: JB = KB = C&D, JC = D|B, KC = D, JD = 1 and KD = ~B&C. As a result, every one of the eight codes has the successor given by R1 and R3.
- R8: Both cell implementations (JK_STYLE 0 and 1) produce identical state sequences for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by all three state bits |
| rst_i | input | 1 | Synchronous active-high reset to 3'b001 |
| en_i | input | 1 | Clock enable; the state advances only while this is high |
| seed_we_i | input | 1 | Forces seed_val_i into the state at the next edge |
| seed_val_i | input | STATE_W | Code to force into the state |
| state_o | output | STATE_W | Current state {B, C, D} |
| start_o | output | 1 | High while the state is the first value of the sequence |

## Verification
The bench builds the block twice, side by side: one copy with JK_STYLE 0 (the decoded selector) and one with JK_STYLE 1 (the characteristic equation). Every check compares both copies against the same expected value. This puts the agreement of the two cell variants within reach, alongside every entry of the successor table, including the four codes the free-running cycle never visits. STATE_W stays at 3, the only width the equations are defined for.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

   localparam int unsigned SG_W   = 3;
   localparam int unsigned BIT_B  = 2;
   localparam int unsigned BIT_C  = 1;
   localparam int unsigned BIT_D  = 0;

   typedef logic [SG_W-1:0] sg_code_t;

   typedef struct packed {
      logic j;
      logic k;
   } jk_pair_t;

   localparam sg_code_t SG_FIRST = 3'b001;

   function automatic logic sg_in_cycle(input sg_code_t c);
      return (c == 3'b001) || (c == 3'b011) || (c == 3'b100) || (c == 3'b111);
   endfunction

endpackage

// File: rtl/seqgen_excite.sv
module seqgen_excite
   import seqgen_pkg::*;
#(
   parameter int unsigned STATE_W = 3
) (
   input  logic [STATE_W-1:0]   cur_i,
   output jk_pair_t [STATE_W-1:0] drive_o
);

   logic qb, qc, qd;

   assign qb = cur_i[BIT_B];
   assign qc = cur_i[BIT_C];
   assign qd = cur_i[BIT_D];

   always_comb begin
      drive_o            = '0;
      drive_o[BIT_B].j   = qc & qd;
      drive_o[BIT_B].k   = qc & qd;
      drive_o[BIT_C].j   = qd | qb;
      drive_o[BIT_C].k   = qd;
      drive_o[BIT_D].j   = 1'b1;
      drive_o[BIT_D].k   = ~qb & qc;
   end

endmodule

// File: rtl/seqgen_jk_cell.sv
module seqgen_jk_cell #(
   parameter int unsigned JK_STYLE = 0,
   parameter bit          RST_BIT  = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ce_i,
   input  logic ld_i,
   input  logic ld_bit_i,
   input  logic j_i,
   input  logic k_i,
   output logic q_o
);

   logic q_q;
   logic q_nxt;

   generate
      if (JK_STYLE > 1) begin : g_bad_style
         $error("seqgen_jk_cell: JK_STYLE must be 0 or 1");
      end

      if (JK_STYLE == 0) begin : g_decoded
         always_comb begin
            unique case ({j_i, k_i})
               2'b00:   q_nxt = q_q;
               2'b01:   q_nxt = 1'b0;
               2'b10:   q_nxt = 1'b1;
               default: q_nxt = ~q_q;
            endcase
         end
      end else begin : g_charact
         assign q_nxt = (j_i & ~q_q) | (~k_i & q_q);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)      q_q <= RST_BIT;
      else if (ld_i)  q_q <= ld_bit_i;
      else if (ce_i)  q_q <= q_nxt;
   end

   assign q_o = q_q;

   // R7: storage cell behaviour for each J/K combination
   p_jk_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && !ld_i && !j_i && !k_i) |=> $stable(q_q));
   p_jk_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && !ld_i && !j_i && k_i) |=> !q_q);
   p_jk_set_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && !ld_i && j_i && !k_i) |=> q_q);
   p_jk_toggle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && !ld_i && j_i && k_i) |=> (q_q != $past(q_q)));

endmodule

// File: rtl/seqgen_1347.sv
module seqgen_1347
   import seqgen_pkg::*;
#(
   parameter int unsigned STATE_W  = 3,
   parameter int unsigned JK_STYLE = 0
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   input  logic               seed_we_i,
   input  logic [STATE_W-1:0] seed_val_i,
   output logic [STATE_W-1:0] state_o,
   output logic               start_o
);

   localparam sg_code_t START_CODE = SG_FIRST;

   logic [STATE_W-1:0]     state_q;
   jk_pair_t [STATE_W-1:0] drive;
   logic                   in_cycle;

   generate
      if (STATE_W != SG_W) begin : g_bad_width
         $error("seqgen_1347: STATE_W must equal 3");
      end
   endgenerate

   seqgen_excite #(
      .STATE_W (STATE_W)
   ) u_excite (
      .cur_i   (state_q),
      .drive_o (drive)
   );

   generate
      for (genvar g = 0; g < STATE_W; g++) begin : g_bit
         seqgen_jk_cell #(
            .JK_STYLE (JK_STYLE),
            .RST_BIT  (START_CODE[g])
         ) u_cell (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .ce_i     (en_i),
            .ld_i     (seed_we_i),
            .ld_bit_i (seed_val_i[g]),
            .j_i      (drive[g].j),
            .k_i      (drive[g].k),
            .q_o      (state_q[g])
         );
      end
   endgenerate

   assign in_cycle = sg_in_cycle(state_q);
   assign state_o  = state_q;
   assign start_o  = (state_q == START_CODE);

   // R2: reset lands on the first value whatever else is driven
   p_reset_value_r2: assert property (@(posedge clk_i)
      rst_i |=> (state_o == START_CODE));
   // R4: no enable, no seed -> state frozen
   p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!en_i && !seed_we_i) |=> $stable(state_o));
   // R1: the cycle is closed under enabled stepping
   p_cycle_closed_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !seed_we_i && in_cycle) |=> sg_in_cycle(state_o));
   // R3: every unused code re-enters the cycle in one step
   p_unused_exit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !seed_we_i && !in_cycle) |=> sg_in_cycle(state_o));
   // R5: seed written into the state
   p_seed_load_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      seed_we_i |=> (state_o == $past(seed_val_i)));
   // R6: start flag never lasts two enabled steps
   p_start_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_o && en_i && !seed_we_i) |=> !start_o);

endmodule

// File: tb/seqgen_1347_tb.sv
`timescale 1ns/100ps
module seqgen_1347_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic       en;
   logic       seed_we;
   logic [2:0] seed_val;
   logic [2:0] st_a, st_b;
   logic       sf_a, sf_b;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // {seed, expected successor}
   localparam logic [5:0] VEC [0:7] = '{
      6'o01, 6'o13, 6'o23, 6'o34, 6'o47, 6'o57, 6'o67, 6'o71
   };
   localparam logic [2:0] RUN [0:3] = '{3'd1, 3'd3, 3'd4, 3'd7};

   always #2.5 clk = ~clk;

   seqgen_1347 #(.STATE_W(3), .JK_STYLE(0)) u_dut (
      .clk_i(clk), .rst_i(rst), .en_i(en), .seed_we_i(seed_we),
      .seed_val_i(seed_val), .state_o(st_a), .start_o(sf_a));

   seqgen_1347 #(.STATE_W(3), .JK_STYLE(1)) u_dut_alt (
      .clk_i(clk), .rst_i(rst), .en_i(en), .seed_we_i(seed_we),
      .seed_val_i(seed_val), .state_o(st_b), .start_o(sf_b));

   task automatic tick(input logic r, input logic we, input logic e, input logic [2:0] v);
      @(negedge clk);
      rst = r; seed_we = we; en = e; seed_val = v;
      @(posedge clk);
      #1;
   endtask

   task automatic chk_state(input string tag, input logic [2:0] exp);
      total++;
      if (st_a !== exp) begin
         bad++;
         $display("FAIL %s state (style0): got %0d expected %0d", tag, st_a, exp);
      end
      total++;
      if (st_b !== exp) begin
         bad++;
         $display("FAIL %s R8 state (style1): got %0d expected %0d", tag, st_b, exp);
      end
   endtask

   task automatic chk_start(input string tag, input logic exp);
      total++;
      if (sf_a !== exp || sf_b !== exp) begin
         bad++;
         $display("FAIL %s start: got %0b/%0b expected %0b", tag, sf_a, sf_b, exp);
      end
   endtask

   initial begin
      rst = 1'b1; en = 1'b0; seed_we = 1'b0; seed_val = 3'd0;
      tick(1'b1, 1'b0, 1'b0, 3'd0);
      tick(1'b1, 1'b0, 1'b0, 3'd0);
      chk_state("R2 reset value", 3'd1);
      chk_start("R6 start after reset", 1'b1);

      // successor table for every code, both variants
      for (int i = 0; i < 8; i++) begin
         logic [2:0] s, n;
         s = VEC[i][5:3];
         n = VEC[i][2:0];
         tick(1'b0, 1'b1, 1'b0, s);
         chk_state("R5 seed load", s);
         chk_start("R6 start vs code", s == 3'd1);
         tick(1'b0, 1'b0, 1'b1, 3'd0);
         if (s == 3'd0 || s == 3'd2 || s == 3'd5 || s == 3'd6)
            chk_state("R3 R7 unused successor", n);
         else
            chk_state("R1 R7 cycle successor", n);
      end

      // three full cycles from reset
      tick(1'b1, 1'b0, 1'b0, 3'd0);
      for (int k = 1; k <= 12; k++) begin
         tick(1'b0, 1'b0, 1'b1, 3'd0);
         chk_state("R1 free run", RUN[k % 4]);
         chk_start("R6 free run start", (k % 4) == 0);
      end

      // hold with enable low
      tick(1'b0, 1'b1, 1'b0, 3'd4);
      for (int k = 0; k < 3; k++) begin
         tick(1'b0, 1'b0, 1'b0, 3'd0);
         chk_state("R4 hold", 3'd4);
      end

      // hold on an unused code too
      tick(1'b0, 1'b1, 1'b0, 3'd6);
      tick(1'b0, 1'b0, 1'b0, 3'd0);
      chk_state("R4 hold unused", 3'd6);

      // reset beats seed and enable
      tick(1'b1, 1'b1, 1'b1, 3'd6);
      chk_state("R2 reset priority", 3'd1);

      // seed beats enable
      tick(1'b0, 1'b1, 1'b1, 3'd5);
      chk_state("R5 seed over enable", 3'd5);
      chk_start("R6 no start on 5", 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule